// File: doc/BRIEF.md
# Edge-Selectable Serial Register Port

This block is the slave side of a synchronous serial link through which a host configures a data-acquisition device and reads its conversion results. The host lowers chip select, clocks in a command byte, and then clocks register data in or out. A static input picks whether the serial clock samples on its rising or its falling edge. A second static input picks a 2-wire mode. In that mode every outgoing data bit is also driven back onto the data-in line, so a host with one shared data wire can read it.

All serial inputs are asynchronous to the system clock. They are synchronised and edge-detected inside the block. The block holds a bank of ten byte registers. Registers 0 and 1 hold the latest 12-bit two's-complement result together with an overload indicator. Register 2 holds the individual overload flags. Registers 3 to 9 are host-writable configuration. Bit 0 of register 3 chooses whether data bits move least-significant first. Each accepted write or read command is announced to the rest of the device by a one-cycle strobe that carries the address and width. Result capture runs independently of chip select.

Top module: `ser_reg_port`

## Requirements
- R1: When `edge_rise` is 0, `din` is sampled and `dout` advances on falling `sclk` edges. When it is 1, both happen on rising edges.
- R2: While `cs_n` is high (after synchronisation), `dout_oe` and `din_oe` are 0. While it is low, `dout_oe` is 1.
- R3: A rising edge on `cs_n` discards any partly received byte or transfer, and the next bits are taken as a new command byte. While `cs_n` is high, no strobe is issued.
- R4: The command byte is sent MSB first. Bit 7 = 1 marks a register access, and a byte with bit 7 = 0 is dropped with no strobe. Bit 6 = 1 means read and 0 means write. Bit 5 = 1 means a 16-bit transfer. Bits 4..0 hold the address.
- R5: A write stores its data. A 16-bit transfer at address A maps register A to bits 7..0 and register A+1 to bits 15..8, and is sent bit 15 first. An accepted write pulses `wr_stb` for one cycle with `wr_addr`, `wr_wide` and `wr_data`. The upper byte of `wr_data` is zero for 8-bit writes.
- R6: Registers 0 to 2 are read-only. Addresses 10 to 31 read as zero. Writes to any of these registers are ignored, and `wr_stb` pulses only if at least one byte of the write lands in registers 3 to 9.
- R7: A low `rst_n` clears all ten registers to zero and returns the port to waiting for a command.
- R8: A one-cycle `res_load` captures the result whatever the state of `cs_n`. Register 1 gets `res_value[11:4]`. Register 0 gets `{res_value[3:0], 3'b000, OR of res_flags}`. Register 2 gets `{4'b0000, res_flags}`.
- R9: When register 3 bit 0 is 1, data bits (not the command byte) are sent and received LSB first. The order is fixed when the command byte completes.
- R10: In 2-wire mode, during the read-data phase, `din_oe` is 1 and `din_o` equals `dout`. In 3-wire mode, `din_oe` stays 0.
- R11: A read command pulses `rd_stb` for one cycle with `rd_addr` and `rd_wide`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low master reset |
| sclk | input | 1 | Serial clock from host (asynchronous) |
| cs_n | input | 1 | Chip select, active low (asynchronous) |
| edge_rise | input | 1 | 1: rising sclk edge active, 0: falling |
| two_wire | input | 1 | 1: mirror output data onto data-in line |
| din | input | 1 | Serial data from host |
| dout | output | 1 | Serial data to host |
| dout_oe | output | 1 | Output enable for dout |
| din_o | output | 1 | Data driven onto data-in line in 2-wire mode |
| din_oe | output | 1 | Output enable for the data-in line |
| res_load | input | 1 | One-cycle pulse: new conversion result |
| res_value | input | 12 | Two's-complement conversion result |
| res_flags | input | 4 | Out-of-range flags from the conversion |
| wr_stb | output | 1 | Register write strobe |
| wr_addr | output | 5 | Write address |
| wr_wide | output | 1 | Write was 16-bit |
| wr_data | output | 16 | Write data |
| rd_stb | output | 1 | Register read strobe |
| rd_addr | output | 5 | Read address |
| rd_wide | output | 1 | Read was 16-bit |

## Verification
The assertions check these cycle-level properties on every cycle:
- the output enables stay off and no strobe appears while chip select is held high;
- in 2-wire mode the mirrored line always carries the same bit as `dout`;
- strobes last exactly one cycle;
- `wr_stb` is never raised for an address that cannot hold any of the written bytes.

Some properties appear only in the bench's transaction scenarios. These are:
- correct sampling on each chosen clock edge;
- the bit order for both MSB-first and LSB-first data;
- the register layout of a captured result;
- dropped command bytes;
- abandoning a partial byte;
- the values read back after a master reset.

// File: rtl/ser_reg_pkg.sv
// Package: shared state encoding, command-byte field positions and
// bit-reversal helpers for the serial register port.
package ser_reg_pkg;

    typedef enum logic [1:0] {
        PS_CMD = 2'd0,
        PS_WR  = 2'd1,
        PS_RD  = 2'd2
    } port_state_t;

    localparam int CMD_W        = 8;
    localparam int CMD_ACC_BIT  = 7;
    localparam int CMD_RD_BIT   = 6;
    localparam int CMD_WIDE_BIT = 5;
    localparam int ADDR_W       = 5;
    localparam int WORD_W       = 16;
    localparam int BYTE_W       = 8;

    // Reverse the order of the bits in a byte.
    function automatic logic [BYTE_W-1:0] rev8(input logic [BYTE_W-1:0] v);
        logic [BYTE_W-1:0] r;
        for (int i = 0; i < BYTE_W; i++) r[i] = v[BYTE_W-1-i];
        return r;
    endfunction

    // Reverse the order of the bits in a 16-bit word.
    function automatic logic [WORD_W-1:0] rev16(input logic [WORD_W-1:0] v);
        logic [WORD_W-1:0] r;
        for (int i = 0; i < WORD_W; i++) r[i] = v[WORD_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/ser_edge_sync.sv
// Module: ser_edge_sync
// Brings sclk, cs_n and din into the clk domain through STAGES-deep
// synchronisers. It then detects the selected active sclk edge and the
// rising (deselect) edge of chip select.
// Assumes: rise_sel is static while chip select is low, and the serial
// clock runs well below clk/(2*(STAGES+1)).
module ser_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk,
    input  logic cs_n,
    input  logic din,
    input  logic rise_sel,
    output logic act_edge,
    output logic cs_act,
    output logic cs_rise,
    output logic din_s
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sclk_q;
    logic [STAGES-1:0] cs_q;
    logic [STAGES-1:0] din_q;
    logic              sclk_d;
    logic              cs_d;
    logic              sclk_rise;
    logic              sclk_fall;

    // Synchroniser chains plus one history flop for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= '0;
            cs_q   <= '1;
            din_q  <= '0;
            sclk_d <= 1'b0;
            cs_d   <= 1'b1;
        end else begin
            sclk_q[0] <= sclk;
            cs_q[0]   <= cs_n;
            din_q[0]  <= din;
            for (int i = 1; i < STAGES; i++) begin
                sclk_q[i] <= sclk_q[i-1];
                cs_q[i]   <= cs_q[i-1];
                din_q[i]  <= din_q[i-1];
            end
            sclk_d <= sclk_q[LAST];
            cs_d   <= cs_q[LAST];
        end
    end

    // Edge decode in the clk domain; edges count only while selected.
    always_comb begin
        sclk_rise = sclk_q[LAST] & ~sclk_d;
        sclk_fall = ~sclk_q[LAST] & sclk_d;
        cs_act    = ~cs_q[LAST];
        cs_rise   = cs_q[LAST] & ~cs_d;
        act_edge  = cs_act & (rise_sel ? sclk_rise : sclk_fall);
        din_s     = din_q[LAST];
    end

endmodule

// File: rtl/ser_port_ctrl.sv
// Module: ser_port_ctrl
// Serial protocol engine. It collects the command byte, then either
// collects write data or shifts read data out. On completion it issues
// the write-commit and read strobes.
// Assumes: act_edge is already qualified by chip select, and look_word
// is a combinational read of the register bank at look_addr.
module ser_port_ctrl
    import ser_reg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              act_edge,
    input  logic              cs_rise,
    input  logic              din_s,
    input  logic              lsb_cfg,
    input  logic [WORD_W-1:0] look_word,
    output logic [ADDR_W-1:0] look_addr,
    output logic              commit,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_wide,
    output logic [WORD_W-1:0] wr_word,
    output logic              rd_stb,
    output logic              sdo,
    output logic              rd_phase
);

    port_state_t       state;
    logic [3:0]        cnt;
    logic [WORD_W-1:0] in_sr;
    logic [WORD_W-1:0] out_sr;
    logic              lsb_q;
    logic [CMD_W-1:0]  byte_next;
    logic [WORD_W-1:0] word_next;
    logic [WORD_W-1:0] load_val;
    logic [WORD_W-1:0] wr_fmt;
    logic              data_last;

    // Next shift-register images and the formatted load/commit values.
    always_comb begin
        word_next = {in_sr[WORD_W-2:0], din_s};
        byte_next = word_next[CMD_W-1:0];
        look_addr = byte_next[ADDR_W-1:0];
        if (byte_next[CMD_WIDE_BIT])
            load_val = lsb_cfg ? rev16(look_word) : look_word;
        else
            load_val = {(lsb_cfg ? rev8(look_word[BYTE_W-1:0])
                                 : look_word[BYTE_W-1:0]), {BYTE_W{1'b0}}};
        if (cmd_wide)
            wr_fmt = lsb_q ? rev16(word_next) : word_next;
        else
            wr_fmt = {{BYTE_W{1'b0}}, (lsb_q ? rev8(word_next[BYTE_W-1:0])
                                             : word_next[BYTE_W-1:0])};
        data_last = cmd_wide ? (cnt == 4'd15) : (cnt == 4'd7);
    end

    // Protocol state machine, advanced once per active serial edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= PS_CMD;
            cnt      <= '0;
            in_sr    <= '0;
            out_sr   <= '0;
            lsb_q    <= 1'b0;
            cmd_addr <= '0;
            cmd_wide <= 1'b0;
            wr_word  <= '0;
            commit   <= 1'b0;
            rd_stb   <= 1'b0;
        end else begin
            commit <= 1'b0;
            rd_stb <= 1'b0;
            if (cs_rise) begin
                state <= PS_CMD;
                cnt   <= '0;
            end else if (act_edge) begin
                in_sr <= word_next;
                cnt   <= cnt + 4'd1;
                unique case (state)
                    PS_CMD: begin
                        if (cnt == 4'd7) begin
                            cnt <= '0;
                            if (byte_next[CMD_ACC_BIT]) begin
                                cmd_addr <= byte_next[ADDR_W-1:0];
                                cmd_wide <= byte_next[CMD_WIDE_BIT];
                                lsb_q    <= lsb_cfg;
                                if (byte_next[CMD_RD_BIT]) begin
                                    state  <= PS_RD;
                                    rd_stb <= 1'b1;
                                    out_sr <= load_val;
                                end else begin
                                    state <= PS_WR;
                                end
                            end
                        end
                    end
                    PS_WR: begin
                        if (data_last) begin
                            state   <= PS_CMD;
                            cnt     <= '0;
                            commit  <= 1'b1;
                            wr_word <= wr_fmt;
                        end
                    end
                    PS_RD: begin
                        out_sr <= {out_sr[WORD_W-2:0], 1'b0};
                        if (data_last) begin
                            state <= PS_CMD;
                            cnt   <= '0;
                        end
                    end
                    default: state <= PS_CMD;
                endcase
            end
        end
    end

    // Serial output bit, and the phase flag that drives the enables.
    always_comb begin
        rd_phase = (state == PS_RD);
        sdo      = rd_phase & out_sr[WORD_W-1];
    end

endmodule

// File: rtl/ser_regbank.sv
// Module: ser_regbank
// Bank of NREG byte registers. The first three are loaded from the
// converter result. The rest are written through commit. Unimplemented
// addresses read as zero.
// Assumes: commit lasts one cycle and cmd_addr/cmd_wide/wr_word are
// held stable around it.
module ser_regbank
    import ser_reg_pkg::*;
#(
    parameter int NREG    = 10,
    parameter int RO_REGS = 3,
    parameter int CFG_REG = 3,
    parameter int RES_W   = 12,
    parameter int NFLAG   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_value,
    input  logic [NFLAG-1:0]  res_flags,
    input  logic [ADDR_W-1:0] look_addr,
    output logic [WORD_W-1:0] look_word,
    input  logic              commit,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              cmd_wide,
    input  logic [WORD_W-1:0] wr_word,
    output logic              wr_ok,
    output logic              lsb_cfg
);

    localparam int PAD = WORD_W - RES_W - 1;
    localparam int AX  = ADDR_W + 1;

    logic [NREG-1:0][BYTE_W-1:0] regs;
    logic [WORD_W-1:0]           res_word;
    logic [BYTE_W-1:0]           flag_byte;
    logic [AX-1:0]               lo_a;
    logic [AX-1:0]               hi_a;
    logic [AX-1:0]               la;
    logic [AX-1:0]               lb;
    logic                        lo_ok;
    logic                        hi_ok;
    logic [BYTE_W-1:0]           lo_b;
    logic [BYTE_W-1:0]           hi_b;

    // Result packing and write-address acceptance.
    always_comb begin
        res_word  = {res_value, {PAD{1'b0}}, |res_flags};
        flag_byte = {{(BYTE_W-NFLAG){1'b0}}, res_flags};
        lo_a      = {1'b0, cmd_addr};
        hi_a      = lo_a + AX'(1);
        lo_ok     = (lo_a >= AX'(RO_REGS)) && (lo_a < AX'(NREG));
        hi_ok     = cmd_wide && (hi_a >= AX'(RO_REGS)) && (hi_a < AX'(NREG));
        wr_ok     = commit & (lo_ok | hi_ok);
    end

    // One register per generate branch, chosen by its role.
    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic [BYTE_W-1:0] q;
        if (g == 0) begin : g_res_lo
            // Low result byte with the overload OR in bit 0.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (res_load) q <= res_word[BYTE_W-1:0];
            end
        end else if (g == 1) begin : g_res_hi
            // High result byte.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (res_load) q <= res_word[WORD_W-1:BYTE_W];
            end
        end else if (g < RO_REGS) begin : g_flags
            // Individual out-of-range flags.
            always_ff @(posedge clk) begin
                if (!rst_n)        q <= '0;
                else if (res_load) q <= flag_byte;
            end
        end else begin : g_cfg
            // Host-writable configuration byte.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    q <= '0;
                else if (commit && lo_ok && lo_a == AX'(g))
                    q <= wr_word[BYTE_W-1:0];
                else if (commit && hi_ok && hi_a == AX'(g))
                    q <= wr_word[WORD_W-1:BYTE_W];
            end
        end
        assign regs[g] = q;
    end

    // Combinational read port: a byte pair, zero outside the bank.
    always_comb begin
        la   = {1'b0, look_addr};
        lb   = la + AX'(1);
        lo_b = '0;
        hi_b = '0;
        for (int i = 0; i < NREG; i++) begin
            if (la == AX'(i)) lo_b = regs[i];
            if (lb == AX'(i)) hi_b = regs[i];
        end
        look_word = {hi_b, lo_b};
        lsb_cfg   = regs[CFG_REG][0];
    end

endmodule

// File: rtl/ser_reg_port.sv
// Module: ser_reg_port (top)
// Serial register port. It has a selectable active clock edge and an
// optional 2-wire output mirror, and it issues parallel read/write
// strobes toward the device core.
// Assumes: pad tri-state buffers live outside and use the *_oe outputs.
module ser_reg_port
    import ser_reg_pkg::*;
#(
    parameter int NREG        = 10,
    parameter int RES_W       = 12,
    parameter int NFLAG       = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk,
    input  logic              cs_n,
    input  logic              edge_rise,
    input  logic              two_wire,
    input  logic              din,
    output logic              dout,
    output logic              dout_oe,
    output logic              din_o,
    output logic              din_oe,
    input  logic              res_load,
    input  logic [RES_W-1:0]  res_value,
    input  logic [NFLAG-1:0]  res_flags,
    output logic              wr_stb,
    output logic [4:0]        wr_addr,
    output logic              wr_wide,
    output logic [15:0]       wr_data,
    output logic              rd_stb,
    output logic [4:0]        rd_addr,
    output logic              rd_wide
);

    localparam int RO_REGS = 3;
    localparam int CFG_REG = 3;

    logic              act_edge;
    logic              cs_act;
    logic              cs_rise;
    logic              din_s;
    logic              lsb_cfg;
    logic [WORD_W-1:0] look_word;
    logic [ADDR_W-1:0] look_addr;
    logic              commit;
    logic [ADDR_W-1:0] cmd_addr;
    logic              cmd_wide;
    logic [WORD_W-1:0] wr_word;
    logic              rd_pulse;
    logic              sdo;
    logic              rd_phase;
    logic              wr_ok;

    ser_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .sclk     (sclk),
        .cs_n     (cs_n),
        .din      (din),
        .rise_sel (edge_rise),
        .act_edge (act_edge),
        .cs_act   (cs_act),
        .cs_rise  (cs_rise),
        .din_s    (din_s)
    );

    ser_port_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .act_edge  (act_edge),
        .cs_rise   (cs_rise),
        .din_s     (din_s),
        .lsb_cfg   (lsb_cfg),
        .look_word (look_word),
        .look_addr (look_addr),
        .commit    (commit),
        .cmd_addr  (cmd_addr),
        .cmd_wide  (cmd_wide),
        .wr_word   (wr_word),
        .rd_stb    (rd_pulse),
        .sdo       (sdo),
        .rd_phase  (rd_phase)
    );

    ser_regbank #(
        .NREG    (NREG),
        .RO_REGS (RO_REGS),
        .CFG_REG (CFG_REG),
        .RES_W   (RES_W),
        .NFLAG   (NFLAG)
    ) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .res_load  (res_load),
        .res_value (res_value),
        .res_flags (res_flags),
        .look_addr (look_addr),
        .look_word (look_word),
        .commit    (commit),
        .cmd_addr  (cmd_addr),
        .cmd_wide  (cmd_wide),
        .wr_word   (wr_word),
        .wr_ok     (wr_ok),
        .lsb_cfg   (lsb_cfg)
    );

    // Pin-level outputs and strobe fan-out.
    always_comb begin
        dout    = sdo;
        dout_oe = cs_act;
        din_o   = sdo;
        din_oe  = two_wire & cs_act & rd_phase;
        wr_stb  = wr_ok;
        wr_addr = cmd_addr;
        wr_wide = cmd_wide;
        wr_data = wr_word;
        rd_stb  = rd_pulse;
        rd_addr = cmd_addr;
        rd_wide = cmd_wide;
    end

endmodule

// File: rtl/ser_port_chk.sv
// Module: ser_port_chk
// Cycle-level protocol checks on the ports of ser_reg_port, attached
// with bind.
module ser_port_chk #(
    parameter int NREG = 10
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cs_n,
    input logic       two_wire,
    input logic       dout,
    input logic       dout_oe,
    input logic       din_o,
    input logic       din_oe,
    input logic       wr_stb,
    input logic [4:0] wr_addr,
    input logic       wr_wide,
    input logic       rd_stb
);

    localparam int RO = 3;

    // R2: enables released once deselect has propagated
    assert_oe_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> (!dout_oe && !din_oe));

    // R3: no strobes while deselected
    assert_no_stb_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && $past(cs_n) && $past(cs_n, 2) && $past(cs_n, 3))
        |-> (!wr_stb && !rd_stb));

    // R10: mirror line carries the output bit
    assert_mirror_R10: assert property (@(posedge clk) disable iff (!rst_n)
        din_oe |-> (two_wire && dout_oe && (din_o == dout)));

    // R5: write strobe is a single-cycle pulse
    assert_wr_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> !wr_stb);

    // R11: read strobe is a single-cycle pulse
    assert_rd_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stb |=> !rd_stb);

    // R6: write strobe only for an address that can hold a written byte
    assert_wr_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |-> ((int'(wr_addr) >= RO - 1) && (int'(wr_addr) < NREG)
                    && (wr_wide || int'(wr_addr) >= RO)));

    // R7: quiet outputs on the first cycle after reset
    assert_reset_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!wr_stb && !rd_stb && !din_oe));

endmodule

bind ser_reg_port ser_port_chk #(.NREG(NREG)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cs_n     (cs_n),
    .two_wire (two_wire),
    .dout     (dout),
    .dout_oe  (dout_oe),
    .din_o    (din_o),
    .din_oe   (din_oe),
    .wr_stb   (wr_stb),
    .wr_addr  (wr_addr),
    .wr_wide  (wr_wide),
    .rd_stb   (rd_stb)
);

// File: tb/sim_ser_reg_port.sv
module sim_ser_reg_port;

    localparam int HALF = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b1;
    logic        cs_n = 1'b1;
    logic        edge_rise = 1'b0;
    logic        two_wire = 1'b0;
    logic        din = 1'b0;
    logic        dout, dout_oe, din_o, din_oe;
    logic        res_load = 1'b0;
    logic [11:0] res_value = '0;
    logic [3:0]  res_flags = '0;
    logic        wr_stb, wr_wide, rd_stb, rd_wide;
    logic [4:0]  wr_addr, rd_addr;
    logic [15:0] wr_data;

    int n_chk = 0;
    int n_err = 0;
    int mir_err = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;
    logic [4:0]  last_wa, last_ra;
    logic [15:0] last_wd;

    always #5 clk = ~clk;

    ser_reg_port u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n),
        .edge_rise(edge_rise), .two_wire(two_wire), .din(din),
        .dout(dout), .dout_oe(dout_oe), .din_o(din_o), .din_oe(din_oe),
        .res_load(res_load), .res_value(res_value), .res_flags(res_flags),
        .wr_stb(wr_stb), .wr_addr(wr_addr), .wr_wide(wr_wide),
        .wr_data(wr_data), .rd_stb(rd_stb), .rd_addr(rd_addr),
        .rd_wide(rd_wide)
    );

    // Strobe monitor, sampled away from the active clock edge.
    always @(negedge clk) begin
        if (wr_stb) begin wr_cnt++; last_wa = wr_addr; last_wd = wr_data; end
        if (rd_stb) begin rd_cnt++; last_ra = rd_addr; end
    end

    function automatic logic [15:0] brev16(input logic [15:0] v);
        logic [15:0] r;
        for (int i = 0; i < 16; i++) r[i] = v[15-i];
        return r;
    endfunction

    function automatic logic [7:0] brev8(input logic [7:0] v);
        logic [7:0] r;
        for (int i = 0; i < 8; i++) r[i] = v[7-i];
        return r;
    endfunction

    // R6 acceptance rule computed from the requirement.
    function automatic bit will_write(input int a, input bit w);
        return (a >= 3 && a <= 9) || (w && a + 1 >= 3 && a + 1 <= 9);
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_level();
        sclk = edge_rise ? 1'b0 : 1'b1;
    endtask

    // Shift n bits; sample dout before each active edge.
    task automatic shift(input int n, input logic [15:0] tx, input bit mir,
                         output logic [15:0] rx);
        rx = '0;
        for (int i = 0; i < n; i++) begin
            idle_level();
            din = tx[n-1-i];
            tick(HALF);
            rx = {rx[14:0], dout};
            if (mir) begin
                if (two_wire && !(din_oe && din_o === dout)) mir_err++;
                if (!two_wire && din_oe) mir_err++;
            end
            sclk = edge_rise ? 1'b1 : 1'b0;
            tick(HALF);
        end
    endtask

    task automatic frame_open();
        idle_level();
        cs_n = 1'b0;
        tick(6);
    endtask

    task automatic frame_close();
        idle_level();
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    task automatic do_write(input int a, input bit w, input logic [15:0] d);
        logic [15:0] junk;
        frame_open();
        shift(8, {8'h00, 1'b1, 1'b0, w, 5'(a)}, 1'b0, junk);
        shift(w ? 16 : 8, d, 1'b0, junk);
        frame_close();
    endtask

    task automatic do_read(input int a, input bit w, output logic [15:0] d);
        logic [15:0] junk;
        frame_open();
        shift(8, {8'h00, 1'b1, 1'b1, w, 5'(a)}, 1'b0, junk);
        shift(w ? 16 : 8, 16'h0000, 1'b1, d);
        frame_close();
    endtask

    task automatic set_mode(input bit er, input bit tw);
        edge_rise = er;
        two_wire  = tw;
        idle_level();
        tick(6);
    endtask

    // {edge_rise, two_wire, wide, addr[4:0], wdata[15:0], expected[15:0]}
    localparam logic [39:0] VEC [9] = '{
        {1'b0, 1'b0, 1'b0, 5'd3,  16'h00FE, 16'h00FE},
        {1'b1, 1'b0, 1'b0, 5'd4,  16'h005A, 16'h005A},
        {1'b0, 1'b1, 1'b0, 5'd9,  16'h00C3, 16'h00C3},
        {1'b1, 1'b1, 1'b1, 5'd5,  16'h1234, 16'h1234},
        {1'b0, 1'b0, 1'b1, 5'd9,  16'hBEEF, 16'h00EF},
        {1'b1, 1'b0, 1'b0, 5'd12, 16'h0077, 16'h0000},
        {1'b0, 1'b1, 1'b0, 5'd1,  16'h0055, 16'h0000},
        {1'b1, 1'b1, 1'b1, 5'd31, 16'hFFFF, 16'h0000},
        {1'b0, 1'b0, 1'b1, 5'd7,  16'hA5C3, 16'hA5C3}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        logic [15:0] rx;
        int w0, r0;
        tick(4);
        rst_n = 1'b1;
        tick(4);

        // Reset state (R2, R7)
        check("R2 dout_oe idle", 32'(dout_oe), 32'd0);
        check("R2 din_oe idle", 32'(din_oe), 32'd0);
        check("R7 no strobes after reset", 32'(wr_cnt + rd_cnt), 32'd0);
        frame_open();
        check("R2 dout_oe selected", 32'(dout_oe), 32'd1);
        frame_close();
        check("R2 dout_oe deselected", 32'(dout_oe), 32'd0);

        // Table walk: write, then read back, across edges and modes (R1, R5, R6, R10, R11)
        for (int k = 0; k < 9; k++) begin
            logic [39:0] v;
            bit w;
            int a;
            logic [15:0] wd, ex;
            v  = VEC[k];
            w  = v[37];
            a  = int'(v[36:32]);
            wd = v[31:16];
            ex = v[15:0];
            set_mode(v[39], v[38]);
            w0 = wr_cnt;
            do_write(a, w, wd);
            check("R6 write strobe count", 32'(wr_cnt - w0), will_write(a, w) ? 32'd1 : 32'd0);
            if (will_write(a, w)) begin
                check("R5 wr_addr", 32'(last_wa), 32'(a));
                check("R5 wr_data", 32'(last_wd), w ? 32'(wd) : 32'(wd[7:0]));
            end
            r0 = rd_cnt;
            mir_err = 0;
            do_read(a, w, rx);
            check("R11 read strobe count", 32'(rd_cnt - r0), 32'd1);
            check("R11 rd_addr", 32'(last_ra), 32'(a));
            check("R1/R5 read back", w ? 32'(rx) : 32'(rx[7:0]), w ? 32'(ex) : 32'(ex[7:0]));
            check("R10 mirror line", 32'(mir_err), 32'd0);
        end

        // R4: dropped command byte followed by a valid write in one frame
        set_mode(1'b0, 1'b0);
        w0 = wr_cnt;
        r0 = rd_cnt;
        frame_open();
        shift(8, 16'h0045, 1'b0, rx);
        shift(8, 16'h0084, 1'b0, rx);
        shift(8, 16'h003C, 1'b0, rx);
        frame_close();
        check("R4 one write after dropped byte", 32'(wr_cnt - w0), 32'd1);
        check("R4 no read from dropped byte", 32'(rd_cnt - r0), 32'd0);
        do_read(4, 1'b0, rx);
        check("R4 reg4 value", 32'(rx[7:0]), 32'h3C);
        w0 = wr_cnt;
        frame_open();
        shift(8, 16'h007F, 1'b0, rx);
        frame_close();
        check("R4 non-access byte ignored", 32'(wr_cnt - w0), 32'd0);

        // R3: partial byte abandoned by deselect
        w0 = wr_cnt;
        frame_open();
        shift(4, 16'h0008, 1'b0, rx);
        frame_close();
        check("R3 no strobe from partial", 32'(wr_cnt - w0), 32'd0);
        do_write(6, 1'b0, 16'h0099);
        do_read(6, 1'b0, rx);
        check("R3 clean command after abandon", 32'(rx[7:0]), 32'h99);

        // R8: result capture while deselected and while selected
        res_value = 12'h9A5;
        res_flags = 4'b0100;
        res_load  = 1'b1;
        tick(1);
        res_load  = 1'b0;
        do_read(0, 1'b1, rx);
        check("R8 result word", 32'(rx), 32'h9A51);
        do_read(2, 1'b0, rx);
        check("R8 flag register", 32'(rx[7:0]), 32'h04);
        frame_open();
        res_value = 12'h3F0;
        res_flags = 4'b0000;
        res_load  = 1'b1;
        tick(1);
        res_load  = 1'b0;
        frame_close();
        do_read(0, 1'b1, rx);
        check("R8 capture with cs low", 32'(rx), 32'h3F00);

        // R9: LSB-first data order
        do_write(3, 1'b0, 16'h0001);
        do_read(0, 1'b1, rx);
        check("R9 lsb-first result", 32'(rx), 32'(brev16(16'h3F00)));
        do_read(3, 1'b0, rx);
        check("R9 lsb-first byte", 32'(rx[7:0]), 32'h80);
        do_write(5, 1'b0, 16'h00C5);
        check("R9 lsb-first write data", 32'(last_wd), 32'(brev8(8'hC5)));
        do_write(3, 1'b0, 16'h0000);
        do_read(5, 1'b0, rx);
        check("R9 msb-first restored", 32'(rx[7:0]), 32'hA3);

        // R7: master reset clears the bank
        rst_n = 1'b0;
        tick(3);
        rst_n = 1'b1;
        tick(4);
        do_read(4, 1'b0, rx);
        check("R7 reg4 cleared", 32'(rx[7:0]), 32'h00);
        do_read(5, 1'b1, rx);
        check("R7 reg5/6 cleared", 32'(rx), 32'h0000);
        do_read(0, 1'b1, rx);
        check("R7 result cleared", 32'(rx), 32'h0000);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule